// File: doc/BRIEF.md
# Hash Engine Job Sequencer

This block is the control front end of a ternary hash or nonce-search engine. A host configures it through a small 32-bit register window: where the input lives, where the result goes, how many trits to process, and which kind of job to run. Once started, a control state machine fetches input words from memory over a simple request/valid read stream and forwards them to the engine. It starts the engine's work and collects the result. It then writes the result to memory over a request/acknowledge write stream and raises an interrupt.

Two job kinds exist. A hash job handles the input in 243-trit blocks. Each block is fetched as a group of 128-bit words and then transformed once, and the cycle repeats until the whole length is covered. A search job fetches the whole input, issues one strobe to start the nonce search, and passes a weight mask to the engine. During a search the block counts the hashes the engine reports. In both job kinds it counts the clock cycles the job takes. Memory addresses count 128-bit words, and each word carries 64 trits at 2 bits per trit.

Top module: `hashctl_top`

## Requirements
- R1: After reset all seven registers read zero, irq is low and neither rd_req nor wr_req is asserted.
- R2: A start accepted from idle makes the block fetch from the source address, with consecutive requests at source+0, source+1, and so on. Only one read is outstanding at a time, and rd_req is a single-cycle pulse.
- R3: In hash mode (control bit 2 = 0) the block processes ceil(len/243) blocks. For each block it fetches exactly 4 words and then gives one eng_xf_start pulse, then waits for eng_xf_done. A length of 0 fetches nothing and runs no transform.
- R4: In search mode (control bit 2 = 1) the block fetches ceil(len/64) words and then gives exactly one eng_pow_start pulse. It runs no transform, and eng_mask carries the value of register 3.
- R5: Every returned read word appears on eng_data with an eng_load pulse, and eng_idx gives its position in the job, counting from 0.
- R6: The result is written to consecutive addresses from the destination address: 4 words for a hash job and 2 words for a search job. The data of word i is eng_result while eng_res_sel = i. wr_req, wr_addr and wr_data stay stable until wr_ack.
- R7: The finish bit (control bit 0) is set in the cycle the last write is acknowledged, and irq follows it. It stays set until the host writes control with bit 0 = 1, or until the next start. While a job runs, control bit 1 reads 1. It reads 0 when idle.
- R8: The cycle counter clears at each accepted start. It then advances once for every cycle the job is busy, so it stops in the same cycle finish is set. Register 5 holds its low 32 bits and register 6 its high 32 bits.
- R9: Register 4 clears at each accepted start and counts the eng_hash_inc pulses received while a search is running.
- R10: While a job runs, a write of the start bit is ignored, and so are writes to the length, mode, source, destination and mask fields. The job continues unchanged and the cycle counter is not cleared.
- R11: Register layout: control is register 0, with length in bits 8 to 23. The source address is register 1, the destination address register 2 and the mask register 3, all read back as written. A read returns the register named by reg_addr one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Job-complete interrupt |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | 32 | Read word address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 128 | Read data word |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_addr | output | 32 | Write word address |
| wr_data | output | 128 | Write data word |
| wr_ack | input | 1 | Write acknowledge |
| eng_load | output | 1 | Input word strobe to engine |
| eng_data | output | 128 | Input word to engine |
| eng_idx | output | 16 | Input word position |
| eng_xf_start | output | 1 | Block transform start pulse |
| eng_xf_done | input | 1 | Transform finished |
| eng_pow_start | output | 1 | Nonce search start pulse |
| eng_pow_done | input | 1 | Search finished |
| eng_hash_inc | input | 1 | One hash evaluated |
| eng_mask | output | 32 | Weight mask to engine |
| eng_res_sel | output | 2 | Result word select |
| eng_result | input | 128 | Selected result word |

## Verification
The bench targets length boundaries: zero, exactly one block, one trit past a block, and partial words in search mode. An off-by-one in the block or word loop shows up there as one fetch or transform too many or too few. It writes start, a new length and a new mode in the middle of a search. A design that accepted that write would restart the fetch, clear the cycle counter, or report the changed length. The bench compares the cycle counter against the busy time it measures itself. A counter that ran one cycle past finish, or that did not clear, gives a different value. It also checks that finish survives idle cycles and clears only when the host writes it.

// File: rtl/hashctl_pkg.sv
package hashctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LWAIT,
    ST_XFORM,
    ST_POW,
    ST_STORE
  } seq_state_e;

  // register indices
  localparam int REG_CTRL = 0;
  localparam int REG_SRC  = 1;
  localparam int REG_DST  = 2;
  localparam int REG_MASK = 3;
  localparam int REG_HCNT = 4;
  localparam int REG_TLO  = 5;
  localparam int REG_THI  = 6;

  // control register bit positions
  localparam int CB_FIN    = 0;
  localparam int CB_GO     = 1;
  localparam int CB_POW    = 2;
  localparam int CB_LEN_LO = 8;
endpackage

// File: rtl/hashctl_cnt.sv
module hashctl_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= q + W'(1);
  end
endmodule

// File: rtl/hashctl_regs.sv
module hashctl_regs
  import hashctl_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 3,
  parameter int LEN_W  = 16,
  parameter int TICK_W = 64,
  parameter int HC_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [HC_W-1:0]   hash_cnt,
  input  logic [TICK_W-1:0] tick_cnt,
  output logic              start,
  output logic [LEN_W-1:0]  len,
  output logic              pow_mode,
  output logic [DW-1:0]     src,
  output logic [DW-1:0]     dst,
  output logic [DW-1:0]     mask,
  output logic              finish
);
  logic            ctrl_hit;
  logic            cfg_ok;
  logic [DW-1:0]   ctrl_rd;
  logic [2*DW-1:0] tick_ext;

  assign ctrl_hit = reg_wr && (reg_addr == AW'(REG_CTRL));
  assign cfg_ok   = reg_wr && !busy;
  assign start    = ctrl_hit && reg_wdata[CB_GO] && !busy;
  assign tick_ext = (2*DW)'(tick_cnt);

  always_comb begin
    ctrl_rd                      = '0;
    ctrl_rd[CB_FIN]              = finish;
    ctrl_rd[CB_GO]               = busy;
    ctrl_rd[CB_POW]              = pow_mode;
    ctrl_rd[CB_LEN_LO +: LEN_W]  = len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len       <= '0;
      pow_mode  <= 1'b0;
      src       <= '0;
      dst       <= '0;
      mask      <= '0;
      finish    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (cfg_ok && reg_addr == AW'(REG_CTRL)) begin
        len      <= reg_wdata[CB_LEN_LO +: LEN_W];
        pow_mode <= reg_wdata[CB_POW];
      end
      if (cfg_ok && reg_addr == AW'(REG_SRC))  src  <= reg_wdata;
      if (cfg_ok && reg_addr == AW'(REG_DST))  dst  <= reg_wdata;
      if (cfg_ok && reg_addr == AW'(REG_MASK)) mask <= reg_wdata;

      if (done)                            finish <= 1'b1;
      else if (start)                      finish <= 1'b0;
      else if (ctrl_hit && reg_wdata[CB_FIN]) finish <= 1'b0;

      case (reg_addr)
        AW'(REG_CTRL): reg_rdata <= ctrl_rd;
        AW'(REG_SRC):  reg_rdata <= src;
        AW'(REG_DST):  reg_rdata <= dst;
        AW'(REG_MASK): reg_rdata <= mask;
        AW'(REG_HCNT): reg_rdata <= DW'(hash_cnt);
        AW'(REG_TLO):  reg_rdata <= tick_ext[DW-1:0];
        AW'(REG_THI):  reg_rdata <= tick_ext[2*DW-1:DW];
        default:       reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/hashctl_fsm.sv
module hashctl_fsm
  import hashctl_pkg::*;
#(
  parameter int MEM_AW      = 32,
  parameter int MEM_DW      = 128,
  parameter int LEN_W       = 16,
  parameter int BLK_TRITS   = 243,
  parameter int WORD_TRITS  = 64,
  parameter int BLK_WORDS   = 4,
  parameter int NONCE_WORDS = 2,
  parameter int SEL_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pow_mode,
  input  logic [LEN_W-1:0]  len,
  input  logic [MEM_AW-1:0] src,
  input  logic [MEM_AW-1:0] dst,
  output logic              busy,
  output logic              in_pow,
  output logic              done,
  output logic              rd_req,
  output logic [MEM_AW-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [MEM_DW-1:0] rd_data,
  output logic              eng_load,
  output logic [MEM_DW-1:0] eng_data,
  output logic [LEN_W-1:0]  eng_idx,
  output logic              eng_xf_start,
  input  logic              eng_xf_done,
  output logic              eng_pow_start,
  input  logic              eng_pow_done,
  output logic [SEL_W-1:0]  eng_res_sel,
  input  logic [MEM_DW-1:0] eng_result,
  output logic              wr_req,
  output logic [MEM_AW-1:0] wr_addr,
  output logic [MEM_DW-1:0] wr_data,
  input  logic              wr_ack
);
  localparam int CW = LEN_W + 1;
  localparam int BW = $clog2(BLK_WORDS + 1);

  seq_state_e       st;
  logic [CW-1:0]    used;      // trits already covered
  logic [LEN_W-1:0] nrd;       // words fetched in this job
  logic [BW-1:0]    blkw;      // words fetched in current block
  logic [SEL_W-1:0] wsel;
  logic [SEL_W-1:0] last_sel;
  logic             more;

  assign busy        = (st != ST_IDLE);
  assign in_pow      = (st == ST_POW);
  assign eng_res_sel = wsel;
  assign last_sel    = pow_mode ? SEL_W'(NONCE_WORDS - 1) : SEL_W'(BLK_WORDS - 1);
  assign more        = (used < {1'b0, len});
  assign done        = (st == ST_STORE) && wr_req && wr_ack && (wsel == last_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      used          <= '0;
      nrd           <= '0;
      blkw          <= '0;
      wsel          <= '0;
      rd_req        <= 1'b0;
      rd_addr       <= '0;
      eng_load      <= 1'b0;
      eng_data      <= '0;
      eng_idx       <= '0;
      eng_xf_start  <= 1'b0;
      eng_pow_start <= 1'b0;
      wr_req        <= 1'b0;
      wr_addr       <= '0;
      wr_data       <= '0;
    end else begin
      rd_req        <= 1'b0;
      eng_load      <= 1'b0;
      eng_xf_start  <= 1'b0;
      eng_pow_start <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st   <= ST_LOAD;
          used <= '0;
          nrd  <= '0;
          blkw <= '0;
          wsel <= '0;
        end
        ST_LOAD: begin
          if (pow_mode) begin
            if (more) begin
              rd_req  <= 1'b1;
              rd_addr <= src + MEM_AW'(nrd);
              st      <= ST_LWAIT;
            end else begin
              eng_pow_start <= 1'b1;
              st            <= ST_POW;
            end
          end else if (!more) begin
            st <= ST_STORE;
          end else if (blkw == BW'(BLK_WORDS)) begin
            eng_xf_start <= 1'b1;
            st           <= ST_XFORM;
          end else begin
            rd_req  <= 1'b1;
            rd_addr <= src + MEM_AW'(nrd);
            st      <= ST_LWAIT;
          end
        end
        ST_LWAIT: if (rd_valid) begin
          eng_load <= 1'b1;
          eng_data <= rd_data;
          eng_idx  <= nrd;
          nrd      <= nrd + LEN_W'(1);
          blkw     <= blkw + BW'(1);
          if (pow_mode) used <= used + CW'(WORD_TRITS);
          st       <= ST_LOAD;
        end
        ST_XFORM: if (eng_xf_done) begin
          used <= used + CW'(BLK_TRITS);
          blkw <= '0;
          st   <= ST_LOAD;
        end
        ST_POW: if (eng_pow_done) st <= ST_STORE;
        ST_STORE: begin
          if (!wr_req) begin
            wr_req  <= 1'b1;
            wr_addr <= dst + MEM_AW'(wsel);
            wr_data <= eng_result;
          end else if (wr_ack) begin
            wr_req <= 1'b0;
            wsel   <= wsel + SEL_W'(1);
            if (wsel == last_sel) st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hashctl_top.sv
module hashctl_top #(
  parameter int DW          = 32,
  parameter int AW          = 3,
  parameter int MEM_AW      = 32,
  parameter int MEM_DW      = 128,
  parameter int LEN_W       = 16,
  parameter int BLK_TRITS   = 243,
  parameter int NONCE_TRITS = 81,
  parameter int TICK_W      = 64,
  parameter int HC_W        = 32,
  parameter int SEL_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq,
  output logic              rd_req,
  output logic [MEM_AW-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [MEM_DW-1:0] rd_data,
  output logic              wr_req,
  output logic [MEM_AW-1:0] wr_addr,
  output logic [MEM_DW-1:0] wr_data,
  input  logic              wr_ack,
  output logic              eng_load,
  output logic [MEM_DW-1:0] eng_data,
  output logic [LEN_W-1:0]  eng_idx,
  output logic              eng_xf_start,
  input  logic              eng_xf_done,
  output logic              eng_pow_start,
  input  logic              eng_pow_done,
  input  logic              eng_hash_inc,
  output logic [DW-1:0]     eng_mask,
  output logic [SEL_W-1:0]  eng_res_sel,
  input  logic [MEM_DW-1:0] eng_result
);
  localparam int WORD_TRITS  = MEM_DW / 2;
  localparam int BLK_WORDS   = (BLK_TRITS + WORD_TRITS - 1) / WORD_TRITS;
  localparam int NONCE_WORDS = (NONCE_TRITS + WORD_TRITS - 1) / WORD_TRITS;

  logic              start_go;
  logic              busy;
  logic              in_pow;
  logic              done;
  logic              pow_mode;
  logic              finish;
  logic [LEN_W-1:0]  len;
  logic [DW-1:0]     src;
  logic [DW-1:0]     dst;
  logic [TICK_W-1:0] tick_cnt;
  logic [HC_W-1:0]   hash_cnt;

  assign irq = finish;

  hashctl_regs #(
    .DW(DW), .AW(AW), .LEN_W(LEN_W), .TICK_W(TICK_W), .HC_W(HC_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .hash_cnt(hash_cnt), .tick_cnt(tick_cnt),
    .start(start_go), .len(len), .pow_mode(pow_mode),
    .src(src), .dst(dst), .mask(eng_mask), .finish(finish)
  );

  hashctl_fsm #(
    .MEM_AW(MEM_AW), .MEM_DW(MEM_DW), .LEN_W(LEN_W), .BLK_TRITS(BLK_TRITS),
    .WORD_TRITS(WORD_TRITS), .BLK_WORDS(BLK_WORDS), .NONCE_WORDS(NONCE_WORDS), .SEL_W(SEL_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start_go), .pow_mode(pow_mode), .len(len),
    .src(MEM_AW'(src)), .dst(MEM_AW'(dst)),
    .busy(busy), .in_pow(in_pow), .done(done),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .eng_load(eng_load), .eng_data(eng_data), .eng_idx(eng_idx),
    .eng_xf_start(eng_xf_start), .eng_xf_done(eng_xf_done),
    .eng_pow_start(eng_pow_start), .eng_pow_done(eng_pow_done),
    .eng_res_sel(eng_res_sel), .eng_result(eng_result),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack)
  );

  hashctl_cnt #(.W(TICK_W)) u_tick (
    .clk(clk), .rst(rst), .clr(start_go), .en(busy), .q(tick_cnt)
  );

  hashctl_cnt #(.W(HC_W)) u_hash (
    .clk(clk), .rst(rst), .clr(start_go), .en(in_pow && eng_hash_inc), .q(hash_cnt)
  );
endmodule

// File: rtl/hashctl_chk.sv
module hashctl_chk #(
  parameter int DW     = 32,
  parameter int AW     = 3,
  parameter int MEM_AW = 32,
  parameter int MEM_DW = 128,
  parameter int TICK_W = 64,
  parameter int HC_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              irq,
  input logic              pow_mode,
  input logic              reg_wr,
  input logic [AW-1:0]     reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic              rd_req,
  input logic              wr_req,
  input logic              wr_ack,
  input logic [MEM_AW-1:0] wr_addr,
  input logic [MEM_DW-1:0] wr_data,
  input logic              eng_xf_start,
  input logic              eng_pow_start,
  input logic [TICK_W-1:0] tick_cnt,
  input logic [HC_W-1:0]   hash_cnt
);
  logic go_wr;
  assign go_wr = reg_wr && (reg_addr == '0) && reg_wdata[1];

  assert_single_read_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  assert_xf_hash_only_R3: assert property (@(posedge clk) disable iff (rst)
    eng_xf_start |-> !pow_mode);

  assert_pow_strobe_mode_R4: assert property (@(posedge clk) disable iff (rst)
    eng_pow_start |-> pow_mode);

  assert_write_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_irq_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(wr_ack));

  assert_no_irq_busy_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !irq);

  assert_tick_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (go_wr && !busy) |=> (tick_cnt == '0));

  assert_hash_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (go_wr && !busy) |=> (hash_cnt == '0));

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (go_wr && busy) |=> (tick_cnt != '0));
endmodule

bind hashctl_top hashctl_chk #(
  .DW(DW), .AW(AW), .MEM_AW(MEM_AW), .MEM_DW(MEM_DW), .TICK_W(TICK_W), .HC_W(HC_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .irq(irq), .pow_mode(pow_mode),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .rd_req(rd_req), .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data),
  .eng_xf_start(eng_xf_start), .eng_pow_start(eng_pow_start),
  .tick_cnt(tick_cnt), .hash_cnt(hash_cnt)
);

// File: tb/hashctl_top_test.sv
`timescale 1ns/1ps
module hashctl_top_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         irq;
  logic         rd_req;
  logic [31:0]  rd_addr;
  logic         rd_valid = 1'b0;
  logic [127:0] rd_data = '0;
  logic         wr_req;
  logic [31:0]  wr_addr;
  logic [127:0] wr_data;
  logic         wr_ack = 1'b0;
  logic         eng_load;
  logic [127:0] eng_data;
  logic [15:0]  eng_idx;
  logic         eng_xf_start;
  logic         eng_xf_done = 1'b0;
  logic         eng_pow_start;
  logic         eng_pow_done = 1'b0;
  logic         eng_hash_inc = 1'b0;
  logic [31:0]  eng_mask;
  logic [1:0]   eng_res_sel;
  logic [127:0] eng_result;

  int n_tests = 0;
  int n_fail  = 0;

  // model state
  logic [31:0] exp_src = '0, exp_dst = '0;
  int rd_seen, ld_seen, xf_seen, pow_seen, wr_seen, words_blk, pow_k;
  int rd_pend = 0, xf_pend = 0, pow_left = 0;
  bit pow_fin = 0, wr_wait = 0, pm_m = 0;
  logic [31:0] rd_lat = '0;

  always #4 clk = ~clk;

  function automatic logic [127:0] memw(input logic [31:0] a);
    return {a ^ 32'h5A5A0000, ~a, a + 32'h11, 32'hC0FFEE00 ^ a};
  endfunction

  function automatic logic [127:0] resw(input logic [1:0] s);
    return {4{32'h0BAD0000 + 32'(s)}};
  endfunction

  function automatic logic [31:0] ctrlw(input bit pm, input int len, input bit go);
    return (32'(len[15:0]) << 8) | (32'(pm) << 2) | (32'(go) << 1);
  endfunction

  assign eng_result = resw(eng_res_sel);

  hashctl_top uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .eng_load(eng_load), .eng_data(eng_data),
    .eng_idx(eng_idx), .eng_xf_start(eng_xf_start), .eng_xf_done(eng_xf_done),
    .eng_pow_start(eng_pow_start), .eng_pow_done(eng_pow_done),
    .eng_hash_inc(eng_hash_inc), .eng_mask(eng_mask), .eng_res_sel(eng_res_sel),
    .eng_result(eng_result)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory and engine model, evaluated on every falling edge
  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 1'b0; eng_xf_done = 1'b0; eng_pow_done = 1'b0;
      eng_hash_inc = 1'b0; wr_ack = 1'b0;
      if (rd_pend > 0) begin
        rd_pend--;
        if (rd_pend == 0) begin rd_valid = 1'b1; rd_data = memw(rd_lat); end
      end
      if (rd_req) begin
        chk(rd_addr == exp_src + 32'(rd_seen), "R2 read address", rd_addr, exp_src + 32'(rd_seen));
        rd_lat = rd_addr; rd_seen++; words_blk++; rd_pend = 1;
      end
      if (eng_load) begin
        chk(eng_data == memw(exp_src + 32'(ld_seen)) && eng_idx == 16'(ld_seen),
            "R5 engine word", {eng_idx, eng_data[111:0]}, {16'(ld_seen), memw(exp_src + 32'(ld_seen))});
        ld_seen++;
      end
      if (xf_pend > 0) begin
        xf_pend--;
        if (xf_pend == 0) eng_xf_done = 1'b1;
      end
      if (eng_xf_start) begin
        chk(words_blk == 4 && !pm_m, "R3 words per block", words_blk, 4);
        words_blk = 0; xf_seen++; xf_pend = 2;
      end
      if (eng_pow_start) begin
        pow_seen++; pow_left = pow_k;
      end else if (pow_left > 0) begin
        eng_hash_inc = 1'b1; pow_left--;
        if (pow_left == 0) pow_fin = 1;
      end else if (pow_fin) begin
        eng_pow_done = 1'b1; pow_fin = 0;
      end
      if (wr_req && !wr_wait) begin
        wr_wait = 1;
      end else if (wr_wait) begin
        wr_ack = 1'b1; wr_wait = 0;
        chk(wr_addr == exp_dst + 32'(wr_seen) && wr_data == resw(2'(wr_seen)),
            "R6 result write", {wr_addr, wr_data[95:0]}, {exp_dst + 32'(wr_seen), resw(2'(wr_seen))});
        wr_seen++;
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic run(input bit pm, input int len, input int k, input logic [31:0] s,
                     input logic [31:0] d, input bit poke);
    int n; int er; int ex; int eo;
    logic [31:0] v; logic [31:0] lo; logic [31:0] hi;
    wr_reg(3'd1, s); wr_reg(3'd2, d);
    exp_src = s; exp_dst = d; pow_k = k; pm_m = pm;
    rd_seen = 0; ld_seen = 0; xf_seen = 0; pow_seen = 0; wr_seen = 0; words_blk = 0;
    er = 0; ex = 0;
    if (pm) begin
      for (int c = 0; c < len; c += 64) er++;
    end else begin
      for (int c = 0; c < len; c += 243) ex++;
      er = ex * 4;
    end
    eo = pm ? 2 : 4;
    wr_reg(3'd0, ctrlw(pm, len, 1'b1));
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      reg_wr = 1'b0;
      if (n == 2) begin
        rd_reg(3'd0, v); n++;
        chk(v[1] == 1'b1, "R7 busy bit while running", v[1], 1);
      end
      if (poke && n == 5) begin
        reg_addr = 3'd0; reg_wdata = ctrlw(!pm, 999, 1'b1); reg_wr = 1'b1;
      end
      if (irq) break;
      if (n > 20000) begin chk(0, "R7 job never finished", n, 0); break; end
    end
    reg_wr = 1'b0;
    chk(irq == 1'b1, "R7 irq after job", irq, 1);
    chk(rd_seen == er, pm ? "R4 fetched words" : "R3 fetched words", rd_seen, er);
    chk(xf_seen == ex, "R3 transform count", xf_seen, ex);
    chk(pow_seen == (pm ? 1 : 0), "R4 search strobes", pow_seen, pm ? 1 : 0);
    chk(ld_seen == er, "R5 forwarded words", ld_seen, er);
    chk(wr_seen == eo, "R6 result words", wr_seen, eo);
    rd_reg(3'd5, lo); rd_reg(3'd6, hi);
    chk({hi, lo} == 64'(n), "R8 cycle counter", {hi, lo}, n);
    rd_reg(3'd4, v);
    chk(v == 32'(pm ? k : 0), "R9 hash counter", v, pm ? k : 0);
    repeat (6) @(negedge clk);
    rd_reg(3'd0, v);
    chk(v[0] == 1'b1 && v[1] == 1'b0 && irq, "R7 finish sticky, idle", v[2:0], 3'b001);
    chk(v[23:8] == 16'(len) && v[2] == pm, poke ? "R10 busy control write ignored" : "R11 length field",
        v[23:8], len);
    wr_reg(3'd0, 32'h1);
    rd_reg(3'd0, v);
    chk(v[0] == 1'b0 && irq == 1'b0, "R7 finish cleared by host", {v[0], irq}, 0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 7; a++) begin
      rd_reg(3'(a), v);
      chk(v == 32'h0, "R1 register reset value", v, 0);
    end
    chk(!irq && !rd_req && !wr_req, "R1 outputs idle after reset", {irq, rd_req, wr_req}, 0);

    wr_reg(3'd3, 32'h0000_7FFF);
    rd_reg(3'd3, v);
    chk(v == 32'h7FFF, "R11 mask readback", v, 32'h7FFF);
    chk(eng_mask == 32'h7FFF, "R4 mask to engine", eng_mask, 32'h7FFF);
    wr_reg(3'd1, 32'hABCD_0010);
    rd_reg(3'd1, v);
    chk(v == 32'hABCD_0010, "R11 source readback", v, 32'hABCD_0010);

    run(1'b0, 500, 0, 32'h100, 32'h800, 1'b0);   // three blocks
    run(1'b0, 243, 0, 32'h200, 32'h900, 1'b0);   // exactly one block
    run(1'b0, 244, 0, 32'h300, 32'hA00, 1'b0);   // one trit past a block
    run(1'b0, 0,   0, 32'h400, 32'hB00, 1'b0);   // empty input
    run(1'b1, 130, 20, 32'h500, 32'hC00, 1'b1);  // search with a start written mid-job
    run(1'b1, 0,   1, 32'h600, 32'hD00, 1'b0);   // search with nothing to fetch
    run(1'b1, 64,  3, 32'h700, 32'hE00, 1'b0);   // exactly one word
    rd_reg(3'd3, v);
    chk(v == 32'h7FFF && eng_mask == 32'h7FFF, "R10 mask kept through jobs", v, 32'h7FFF);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog R7 act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule